// File: doc/BRIEF.md
# Reset Sequencer with Clock Qualification

This block orders the chip's way out of reset. A power-on event (asynchronous) or a low-voltage event (synchronous) first sends it into a clock check. The check is a run of fixed-length windows. At the end of each window the oscillator-good indication is sampled. The first good window ends the check and selects the oscillator. If the budget of windows runs out without a good one, the block falls back to the internal self clock. The block then drives the bidirectional reset pin low for a fixed time, lets it go, and looks at the pin again after a settling time. The internal reset is released only when the pin reads high.

A low level on the reset pin while the chip runs starts the drive and settle part of the sequence again, without a new clock check. When a sequence completes, a two-bit cause code is latched for vector selection. The block's own counters come from parameters: window length (default 4096 reference cycles), window budget (50), drive time (128) and settle time (64).

Top module: `rstseq_top`

## Requirements
- R1: While `por_req` is high, and during every clock check, `rst_out` is 1 and `pin_drive_low` is 0. The reset values are `sel_self`=0 and `cause`=0.
- R2: The first check window that ends with `osc_ok`=1 ends the check and sets `sel_self` to 0, which selects the oscillator.
- R3: If `MAX_WINDOWS` consecutive windows all end with `osc_ok`=0, the check ends after the last of them with `sel_self`=1, which selects the self clock. A good result on that last window still selects the oscillator.
- R4: After the check, `pin_drive_low` is high for exactly `DRIVE_CYC` cycles.
- R5: `SAMPLE_CYC` cycles after the drive ends, `pin_in` is sampled. A high level releases `rst_out` at that edge.
- R6: A low `pin_in` at the sample point keeps `rst_out` at 1 until the first edge at which `pin_in` is high.
- R7: The cause code is latched on release, with this priority: 0 for a power-on or low-voltage event since the last release, then 1 when `cm_fail`=1, then 2 for watchdog, otherwise 3 for the external pin.
- R8: Code 2 is chosen only when `cop_flag`=1 and `cm_fail`=0 at the release edge.
- R9: `lvr_req` high at any edge returns the block to the start of the clock check, with the window and failure counts cleared. The drive stops and `rst_out` is 1 from the next cycle.
- R10: `rst_out` stays 1 without a gap from the request until release, and falls only on a clock edge out of the settle or hold phase.
- R11: `pin_in`=0 while running asserts `rst_out` and starts the drive phase at the next edge, with no clock check.
- R12: A check window lasts `WIN_CYCLES` clock cycles. `osc_ok` is looked at only on the window's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all sequencing |
| por_req | input | 1 | Power-on event, asynchronous, active high |
| lvr_req | input | 1 | Low-voltage event, synchronous, active high |
| osc_ok | input | 1 | Oscillator-good result, read at the end of each window |
| cm_fail | input | 1 | Clock-monitor failure flag |
| cop_flag | input | 1 | Latched watchdog time-out flag |
| pin_in | input | 1 | Sampled level of the reset pin |
| pin_drive_low | output | 1 | Enables the pull-down on the reset pin |
| rst_out | output | 1 | Internal reset, active high |
| sel_self | output | 1 | Clock select: 1 = self clock, 0 = oscillator |
| cause | output | 2 | Latched reset cause code |

## Verification
Assertions check the following on every cycle:
- a low-voltage event always lands in the check with the pin released;
- each completed drive lasts exactly the drive count;
- release happens only out of the settle or hold phase, and only with the pin high;
- the watchdog code never appears with a clock-monitor failure present;
- the self clock is chosen only on a failing window;
- the failure count stays within the window budget.

Only the bench's scenarios can show the exact release cycle, for these cases:
- different numbers of failed windows, including the last-window pass and the full fallback;
- the pin held low past the sample point;
- each cause priority;
- a restart part-way through the drive.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_CHECK, ST_DRIVE, ST_RELEASE, ST_HOLD, ST_RUN
  } seq_state_t;

  typedef enum logic [1:0] {
    CAUSE_POWER  = 2'd0,
    CAUSE_CLKMON = 2'd1,
    CAUSE_WDOG   = 2'd2,
    CAUSE_PIN    = 2'd3
  } cause_t;
endpackage

// File: rtl/rstseq_clkqual.sv
`timescale 1ns/1ps
module rstseq_clkqual #(
  parameter int WIN_CYCLES  = 4096,
  parameter int MAX_WINDOWS = 50
) (
  input  logic clk,
  input  logic por_req,
  input  logic restart,
  input  logic active,
  input  logic osc_ok,
  output logic qual_done,
  output logic qual_self
);
  localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int FW = (MAX_WINDOWS > 1) ? $clog2(MAX_WINDOWS) : 1;
  localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_CYCLES - 1);
  localparam logic [FW-1:0] FAIL_LAST = FW'(MAX_WINDOWS - 1);

  logic [WW-1:0] win_cnt;
  logic [FW-1:0] fail_cnt;
  logic          win_end;

  assign win_end   = active && (win_cnt == WIN_LAST);
  assign qual_done = win_end && (osc_ok || (fail_cnt == FAIL_LAST));
  assign qual_self = !osc_ok;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      win_cnt  <= '0;
      fail_cnt <= '0;
    end else if (restart || !active || qual_done) begin
      win_cnt  <= '0;
      fail_cnt <= '0;
    end else if (win_end) begin
      win_cnt  <= '0;
      fail_cnt <= fail_cnt + FW'(1);
    end else begin
      win_cnt <= win_cnt + WW'(1);
    end
  end

  // failure tally never passes the window budget
  p_fail_bound_r3: assert property (@(posedge clk) disable iff (por_req)
    active |-> (int'(fail_cnt) < MAX_WINDOWS));
endmodule

// File: rtl/rstseq_pin_timer.sv
`timescale 1ns/1ps
module rstseq_pin_timer #(
  parameter int DRIVE_CYC  = 128,
  parameter int SAMPLE_CYC = 64
) (
  input  logic clk,
  input  logic por_req,
  input  logic clear,
  input  logic drive_on,
  input  logic release_on,
  output logic drive_end,
  output logic release_end
);
  localparam int CMAX = (DRIVE_CYC > SAMPLE_CYC) ? DRIVE_CYC : SAMPLE_CYC;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;

  logic [CW-1:0] cnt;

  assign drive_end   = drive_on   && (cnt == CW'(DRIVE_CYC - 1));
  assign release_end = release_on && (cnt == CW'(SAMPLE_CYC - 1));

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)
      cnt <= '0;
    else if (clear || drive_end || release_end || !(drive_on || release_on))
      cnt <= '0;
    else
      cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/rstseq_cause.sv
`timescale 1ns/1ps
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic   power_evt,
  input  logic   clkmon_fail,
  input  logic   wdog_flag,
  output cause_t cause_d
);
  always_comb begin
    if (power_evt)        cause_d = CAUSE_POWER;
    else if (clkmon_fail) cause_d = CAUSE_CLKMON;
    else if (wdog_flag)   cause_d = CAUSE_WDOG;
    else                  cause_d = CAUSE_PIN;
  end
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int WIN_CYCLES  = 4096,
  parameter int MAX_WINDOWS = 50,
  parameter int DRIVE_CYC   = 128,
  parameter int SAMPLE_CYC  = 64
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       lvr_req,
  input  logic       osc_ok,
  input  logic       cm_fail,
  input  logic       cop_flag,
  input  logic       pin_in,
  output logic       pin_drive_low,
  output logic       rst_out,
  output logic       sel_self,
  output logic [1:0] cause
);
  seq_state_t state;
  cause_t     cause_q, cause_d;
  logic       power_evt;
  logic       qual_done, qual_self, drive_end, release_end;

  rstseq_clkqual #(.WIN_CYCLES(WIN_CYCLES), .MAX_WINDOWS(MAX_WINDOWS)) u_qual (
    .clk(clk), .por_req(por_req), .restart(lvr_req),
    .active(state == ST_CHECK), .osc_ok(osc_ok),
    .qual_done(qual_done), .qual_self(qual_self)
  );

  rstseq_pin_timer #(.DRIVE_CYC(DRIVE_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_timer (
    .clk(clk), .por_req(por_req), .clear(lvr_req),
    .drive_on(state == ST_DRIVE), .release_on(state == ST_RELEASE),
    .drive_end(drive_end), .release_end(release_end)
  );

  rstseq_cause u_cause (
    .power_evt(power_evt), .clkmon_fail(cm_fail), .wdog_flag(cop_flag),
    .cause_d(cause_d)
  );

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      state     <= ST_CHECK;
      sel_self  <= 1'b0;
      cause_q   <= CAUSE_POWER;
      power_evt <= 1'b1;
    end else if (lvr_req) begin
      state     <= ST_CHECK;
      power_evt <= 1'b1;
    end else begin
      unique case (state)
        ST_CHECK: if (qual_done) begin
          state    <= ST_DRIVE;
          sel_self <= qual_self;
        end
        ST_DRIVE:   if (drive_end) state <= ST_RELEASE;
        ST_RELEASE: if (release_end) begin
          if (pin_in) begin
            state     <= ST_RUN;
            cause_q   <= cause_d;
            power_evt <= 1'b0;
          end else begin
            state <= ST_HOLD;
          end
        end
        ST_HOLD: if (pin_in) begin
          state     <= ST_RUN;
          cause_q   <= cause_d;
          power_evt <= 1'b0;
        end
        ST_RUN: if (!pin_in) state <= ST_DRIVE;
        default: state <= ST_CHECK;
      endcase
    end
  end

  assign pin_drive_low = (state == ST_DRIVE);
  assign rst_out       = (state != ST_RUN);
  assign cause         = cause_q;

  // consecutive drive cycles, kept apart from the timer for checking
  localparam int DSW = $clog2(DRIVE_CYC + 1);
  logic [DSW-1:0] drv_seen;
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)            drv_seen <= '0;
    else if (pin_drive_low) drv_seen <= drv_seen + DSW'(1);
    else                    drv_seen <= '0;
  end

  p_lvr_restart_r9: assert property (@(posedge clk) disable iff (por_req)
    lvr_req |=> (state == ST_CHECK) && rst_out && !pin_drive_low);

  p_drive_len_r4: assert property (@(posedge clk) disable iff (por_req)
    ($fell(pin_drive_low) && !$past(lvr_req)) |-> (drv_seen == DSW'(DRIVE_CYC)));

  p_release_level_r6: assert property (@(posedge clk) disable iff (por_req)
    $fell(rst_out) |-> $past(pin_in));

  p_release_path_r10: assert property (@(posedge clk) disable iff (por_req)
    $fell(rst_out) |-> ($past(state) == ST_RELEASE || $past(state) == ST_HOLD));

  p_wdog_cause_r8: assert property (@(posedge clk) disable iff (por_req)
    ($fell(rst_out) && cause == CAUSE_WDOG) |-> ($past(cop_flag) && !$past(cm_fail)));

  p_self_sel_r3: assert property (@(posedge clk) disable iff (por_req)
    $rose(sel_self) |-> ($past(state) == ST_CHECK && !$past(osc_ok)));

  p_pin_trigger_r11: assert property (@(posedge clk) disable iff (por_req)
    (state == ST_RUN && !pin_in && !lvr_req) |=> pin_drive_low);
endmodule

// File: tb/test_rstseq_top.sv
`timescale 1ns/1ps
module test_rstseq_top;
  localparam int WIN  = 16;
  localparam int MAXW = 50;
  localparam int DRV  = 128;
  localparam int SMP  = 64;
  localparam logic [1:0] TRIG_POR = 2'd0, TRIG_LVR = 2'd1, TRIG_PIN = 2'd2;

  typedef struct packed {
    logic [1:0] trig;
    logic [6:0] fails;
    logic [9:0] hold;
    logic       cm;
    logic       cop;
    logic [1:0] ecause;
    logic       eself;
  } vec_t;

  // R2 R3 R6 R7 R8 R11 R12 scenarios
  localparam vec_t VECS [0:10] = '{
    '{TRIG_POR, 7'd0,  10'd0,   1'b0, 1'b0, 2'd0, 1'b0},  // R2 first window good
    '{TRIG_POR, 7'd3,  10'd0,   1'b0, 1'b0, 2'd0, 1'b0},  // R12 window length
    '{TRIG_PIN, 7'd0,  10'd1,   1'b0, 1'b0, 2'd3, 1'b0},  // R11 pin cause
    '{TRIG_PIN, 7'd0,  10'd1,   1'b1, 1'b1, 2'd1, 1'b0},  // R8 clock monitor wins
    '{TRIG_PIN, 7'd0,  10'd1,   1'b0, 1'b1, 2'd2, 1'b0},  // R8 watchdog
    '{TRIG_POR, 7'd49, 10'd0,   1'b0, 1'b0, 2'd0, 1'b0},  // R3 last window good
    '{TRIG_POR, 7'd60, 10'd0,   1'b0, 1'b0, 2'd0, 1'b1},  // R3 fallback
    '{TRIG_PIN, 7'd0,  10'd1,   1'b0, 1'b0, 2'd3, 1'b1},  // R11 select kept
    '{TRIG_LVR, 7'd1,  10'd0,   1'b1, 1'b0, 2'd0, 1'b0},  // R7 power first
    '{TRIG_PIN, 7'd0,  10'd300, 1'b0, 1'b0, 2'd3, 1'b0},  // R6 pin held
    '{TRIG_POR, 7'd0,  10'd300, 1'b0, 1'b0, 2'd0, 1'b0}   // R6 after power-on
  };

  logic clk = 1'b0;
  logic por_req = 1'b1, lvr_req = 1'b0, osc_ok = 1'b0;
  logic cm_fail = 1'b0, cop_flag = 1'b0, ext_n = 1'b1;
  logic pin_in, pin_drive_low, rst_out, sel_self;
  logic [1:0] cause;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;
  assign pin_in = ext_n & ~pin_drive_low;

  rstseq_top #(.WIN_CYCLES(WIN), .MAX_WINDOWS(MAXW), .DRIVE_CYC(DRV), .SAMPLE_CYC(SMP)) i_rstseq_top (
    .clk(clk), .por_req(por_req), .lvr_req(lvr_req), .osc_ok(osc_ok),
    .cm_fail(cm_fail), .cop_flag(cop_flag), .pin_in(pin_in),
    .pin_drive_low(pin_drive_low), .rst_out(rst_out), .sel_self(sel_self), .cause(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int n, drv, off, w, n0, expn;
    n = 0; drv = 0;
    cm_fail = v.cm; cop_flag = v.cop;
    off  = (v.trig == TRIG_POR) ? 0 : 1;
    w    = (int'(v.fails) >= MAXW) ? MAXW : int'(v.fails) + 1;
    n0   = off + DRV + SMP + ((v.trig == TRIG_PIN) ? 0 : w * WIN);
    expn = (int'(v.hold) >= n0) ? int'(v.hold) + 1 : n0;
    if (v.trig == TRIG_POR) begin
      por_req = 1'b1; @(negedge clk); por_req = 1'b0;
    end
    while (n < 4000) begin
      osc_ok  = (n >= off + int'(v.fails) * WIN);
      ext_n   = !(n < int'(v.hold));
      lvr_req = (v.trig == TRIG_LVR) && (n == 0);
      @(negedge clk);
      n++;
      if (pin_drive_low) drv++;
      if (!rst_out) break;
    end
    lvr_req = 1'b0; ext_n = 1'b1;
    chk("R5/R10/R12 release edge", n, expn);
    chk("R4 drive length", drv, DRV);
    chk("R7 cause code", int'(cause), int'(v.ecause));
    chk("R2/R3 clock select", int'(sel_self), int'(v.eself));
    cm_fail = 1'b0; cop_flag = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst_out in reset", int'(rst_out), 1);
    chk("R1 no drive in reset", int'(pin_drive_low), 0);
    chk("R1 select in reset", int'(sel_self), 0);
    chk("R1 cause in reset", int'(cause), 0);

    for (int i = 0; i <= 10; i++) run_vec(VECS[i]);

    // R9 restart during the drive phase of a pin-started sequence
    ext_n = 1'b0; @(negedge clk); ext_n = 1'b1;
    repeat (49) @(negedge clk);
    chk("R11 drive underway", int'(pin_drive_low), 1);
    lvr_req = 1'b1; osc_ok = 1'b1;
    @(negedge clk);
    lvr_req = 1'b0;
    chk("R9 drive stops", int'(pin_drive_low), 0);
    chk("R9 reset held", int'(rst_out), 1);
    n = 1;
    while (n < 4000 && rst_out) begin
      @(negedge clk);
      n++;
    end
    chk("R9 restart length", n, 1 + WIN + DRV + SMP);
    chk("R7 restart cause", int'(cause), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule